// File: doc/BRIEF.md
# VGA Planar Memory Data Path

This block is the processor-facing side of a four-plane graphics memory. A byte access whose address lands inside a fixed window is turned into a plane offset (address minus the window base). Every accepted read copies the byte at that offset from all four planes into four 8-bit latches. It also returns one of them, picked by the read-plane select, one cycle later.

Writes build a new byte for each plane out of the processor byte, that plane's latch, the set/reset controls, a per-bit mask and one of four logic functions, as chosen by the write mode. Each result is stored only into the planes whose map-mask bit is set. All configuration arrives as static inputs from a separate register block. The four plane arrays are synchronous memories inside the block. Their depth is a parameter: the default is kept small, and a full 64 KB plane uses an offset width of 16.

A read and a write may be presented in the same cycle. The write then combines with the latches as they stood before that read, and the read returns plane contents from before that write.

Top module: `vga_planar_path`

## Requirements
- R1: While reset is low, `rd_valid` is 0. Reset clears all four latches to 0x00, so a write-mode-1 store issued before any read writes 0x00.
- R2: An access whose address is below `WIN_BASE` or at or above `WIN_BASE + 2**OFS_W` has no effect. A read outside the window leaves `rd_valid` at 0 and does not change the latches. A write outside the window changes no plane byte.
- R3: An accepted read raises `rd_valid` in the following cycle. `rd_data` then shows the byte of plane `cfg_read_map` (0..3), with the select sampled in the request cycle.
- R4: An accepted read loads each plane's latch from that plane's byte at the read offset. The latches hold their value until the next accepted read.
- R5: In write mode 0 (`cfg_write_mode` = 0), a plane whose `cfg_sr_en` bit is 1 takes as its source byte its `cfg_set_reset` bit repeated eight times (0x00 or 0xFF).
- R6: In write mode 0, a plane whose `cfg_sr_en` bit is 0 takes `wr_data` as its source byte. `cfg_func` picks how source and latch combine: 0 source only, 1 AND, 2 OR, 3 XOR.
- R7: In write mode 2, plane n takes as its source byte bit n of `wr_data` repeated eight times, and combines it with the latch through `cfg_func`.
- R8: In write modes 1 and 3, each enabled plane stores its own latch byte unchanged, whatever the mask, function or data.
- R9: In modes 0 and 2, a bit position whose `cfg_bit_mask` bit is 0 stores the latch bit. Positions whose mask bit is 1 store the function result.
- R10: Plane n is written only when bit n of `cfg_map_mask` is 1. Other planes keep their byte at that offset.
- R11: When a read and a write at the same offset are accepted in the same cycle, the write uses the latches from before that read. The read returns the bytes from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Read byte address |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Processor write byte |
| cfg_write_mode | input | 2 | Write mode 0..3 |
| cfg_func | input | 2 | Logic function: 0 source, 1 AND, 2 OR, 3 XOR |
| cfg_read_map | input | 2 | Plane returned by a read |
| cfg_set_reset | input | 4 | Per-plane set/reset value |
| cfg_sr_en | input | 4 | Per-plane set/reset enable (mode 0) |
| cfg_bit_mask | input | 8 | Per-bit mask; 1 lets the function result through |
| cfg_map_mask | input | 4 | Per-plane write enable |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |

## Verification
The properties assume that the configuration inputs are steady across the clock edge of each write and hold no unknown values. They also assume that addresses are fully driven whenever `rd_en` or `wr_en` is high. The stimulus changes every input only at the falling clock edge, so each request and its configuration are settled a half period before they are sampled. The only configuration change inside a transaction is a deliberate switch of the read-plane select after the request is accepted, which tests that the select is sampled in the request cycle. A table of write configurations is run first, each over freshly seeded latch contents. Directed cases and a random mix of reads and writes follow, scored against a shadow model of all four planes.

// File: rtl/vga_pp_pkg.sv
package vga_pp_pkg;
    localparam int PLANES = 4;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] pbyte_t;

    typedef enum logic [1:0] {
        WM_LOGIC = 2'd0,
        WM_COPY  = 2'd1,
        WM_SPLAT = 2'd2,
        WM_COPY3 = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } func_e;

    typedef struct packed {
        logic       rd_valid;
        logic [1:0] rd_sel;
    } rd_state_t;
endpackage

// File: rtl/vga_pp_window.sv
module vga_pp_window #(
    parameter int unsigned       ADDR_W   = 20,
    parameter int unsigned       OFS_W    = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [OFS_W-1:0]  ofs
);
    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - WIN_BASE;
        // below the base wraps to a large value, so one compare covers both sides
        hit = (rel[ADDR_W-1:OFS_W] == '0);
        ofs = rel[OFS_W-1:0];
    end
endmodule

// File: rtl/vga_pp_combine.sv
module vga_pp_combine
    import vga_pp_pkg::*;
#(
    parameter int unsigned PLANE = 0
) (
    input  wmode_e mode,
    input  func_e  func,
    input  logic   sr_bit,
    input  logic   sr_en_bit,
    input  pbyte_t cpu,
    input  pbyte_t bit_mask,
    input  pbyte_t latch,
    output pbyte_t result
);
    pbyte_t src_d;
    pbyte_t fn_d;
    logic   copy_d;

    always_comb begin
        copy_d = 1'b0;
        unique case (mode)
            WM_LOGIC: src_d = sr_en_bit ? {BYTE_W{sr_bit}} : cpu;
            WM_SPLAT: src_d = {BYTE_W{cpu[PLANE]}};
            default: begin
                src_d  = latch;
                copy_d = 1'b1;
            end
        endcase

        unique case (func)
            FN_PASS: fn_d = src_d;
            FN_AND:  fn_d = src_d & latch;
            FN_OR:   fn_d = src_d | latch;
            default: fn_d = src_d ^ latch;
        endcase

        result = copy_d ? latch : ((fn_d & bit_mask) | (latch & ~bit_mask));
    end
endmodule

// File: rtl/vga_pp_plane.sv
module vga_pp_plane
    import vga_pp_pkg::*;
#(
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  logic [OFS_W-1:0] rd_ofs,
    input  logic             wr_go,
    input  logic [OFS_W-1:0] wr_ofs,
    input  pbyte_t           wr_byte,
    output pbyte_t           latch
);
    localparam int unsigned DEPTH = 1 << OFS_W;

    pbyte_t mem_q [DEPTH];
    pbyte_t latch_d, latch_q;

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem_q[wr_ofs] <= wr_byte;
        end
    end

    // read-before-write: the latch samples the array before this edge's store lands
    always_comb begin
        latch_d = latch_q;
        if (rd_go) begin
            latch_d = mem_q[rd_ofs];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else begin
            latch_q <= latch_d;
        end
    end

    assign latch = latch_q;
endmodule

// File: rtl/vga_planar_path.sv
module vga_planar_path
    import vga_pp_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 20,
    parameter int unsigned       OFS_W    = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 'hA0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        cfg_write_mode,
    input  logic [1:0]        cfg_func,
    input  logic [1:0]        cfg_read_map,
    input  logic [3:0]        cfg_set_reset,
    input  logic [3:0]        cfg_sr_en,
    input  logic [7:0]        cfg_bit_mask,
    input  logic [3:0]        cfg_map_mask,
    output logic              rd_valid,
    output logic [7:0]        rd_data
);
    logic             rd_hit, wr_hit;
    logic [OFS_W-1:0] rd_ofs, wr_ofs;
    logic             rd_go;

    logic [PLANES-1:0][BYTE_W-1:0] latch;
    logic [PLANES-1:0][BYTE_W-1:0] plane_wdata;
    logic [PLANES-1:0]             plane_we;

    wmode_e mode_e;
    func_e  func_sel;

    rd_state_t st_d, st_q;

    vga_pp_window #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)) u_rd_win (
        .addr (rd_addr),
        .hit  (rd_hit),
        .ofs  (rd_ofs)
    );

    vga_pp_window #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(WIN_BASE)) u_wr_win (
        .addr (wr_addr),
        .hit  (wr_hit),
        .ofs  (wr_ofs)
    );

    assign rd_go    = rd_en & rd_hit;
    assign mode_e   = wmode_e'(cfg_write_mode);
    assign func_sel = func_e'(cfg_func);

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        vga_pp_combine #(.PLANE(p)) u_comb (
            .mode      (mode_e),
            .func      (func_sel),
            .sr_bit    (cfg_set_reset[p]),
            .sr_en_bit (cfg_sr_en[p]),
            .cpu       (wr_data),
            .bit_mask  (cfg_bit_mask),
            .latch     (latch[p]),
            .result    (plane_wdata[p])
        );

        assign plane_we[p] = wr_en & wr_hit & cfg_map_mask[p];

        vga_pp_plane #(.OFS_W(OFS_W)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_go   (rd_go),
            .rd_ofs  (rd_ofs),
            .wr_go   (plane_we[p]),
            .wr_ofs  (wr_ofs),
            .wr_byte (plane_wdata[p]),
            .latch   (latch[p])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = rd_go;
        if (rd_go) begin
            st_d.rd_sel = cfg_read_map;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_valid ? latch[st_q.rd_sel] : 8'h00;
endmodule

// File: rtl/vga_planar_path_chk.sv
module vga_planar_path_chk #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned OFS_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             rd_hit,
    input logic             wr_en,
    input logic [1:0]       cfg_write_mode,
    input logic [7:0]       cfg_bit_mask,
    input logic [3:0]       cfg_map_mask,
    input logic             rd_valid,
    input logic [3:0][7:0]  latch,
    input logic [3:0][7:0]  plane_wdata,
    input logic [3:0]       plane_we
);
    // R1: no read data is flagged while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!rd_valid);
        end
    end

    // R3: an accepted read is answered in the next cycle
    assert_rd_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_hit) |=> rd_valid);

    // R2: a read outside the window or no read gives no valid flag
    assert_rd_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_hit) |=> !rd_valid);

    // R4: latches move only on an accepted read
    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_hit) |=> $stable(latch));

    // R8: copy modes hand each plane its own latch
    assert_copy_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_write_mode[0]) |-> (plane_wdata == latch));

    // R10: no plane store without its map-mask bit or without a write
    assert_map_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_we & ~cfg_map_mask) == 4'b0);

    assert_no_stray_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (plane_we == 4'b0));

    for (genvar p = 0; p < 4; p++) begin : g_mask
        // R9: masked-off bits carry the latch bit
        assert_mask_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (((plane_wdata[p] ^ latch[p]) & ~cfg_bit_mask) == 8'h00));
    end
endmodule

bind vga_planar_path vga_planar_path_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_en          (rd_en),
    .rd_hit         (rd_hit),
    .wr_en          (wr_en),
    .cfg_write_mode (cfg_write_mode),
    .cfg_bit_mask   (cfg_bit_mask),
    .cfg_map_mask   (cfg_map_mask),
    .rd_valid       (rd_valid),
    .latch          (latch),
    .plane_wdata    (plane_wdata),
    .plane_we       (plane_we)
);

// File: tb/sim_vga_planar_path.sv
`timescale 1ns/1ps
module sim_vga_planar_path;
    localparam int          ADDR_W = 20;
    localparam int          OFS_W  = 8;
    localparam logic [19:0] BASE   = 20'hA0000;
    localparam int          DEPTH  = 1 << OFS_W;
    localparam int          NVEC   = 13;

    // {mode,func}[31:28] set_reset[27:24] sr_en[23:20] mask[19:12] map[11:8] cpu[7:0]
    localparam logic [31:0] VEC [NVEC] = '{
        32'h000FFFA5,  // R6 mode0 source only
        32'h100FFF0F,  // R6 AND
        32'h200F0F3C,  // R6 OR, R9 partial mask
        32'h300FFFFF,  // R6 XOR
        32'h0AFFFF00,  // R5 all planes from set/reset
        32'h3633CF81,  // R5 mixed enable, XOR, R9 mask
        32'h800FFF05,  // R7 mode2 source only
        32'h9000FF0A,  // R7 AND, R9
        32'hA0081F03,  // R7 OR
        32'hB00FF50F,  // R7 XOR, R10 planes 0 and 2
        32'h400FFF00,  // R8 mode1
        32'hC0000A77,  // R8 mode3, R10 planes 1 and 3
        32'h00000FFF   // R9 empty mask
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rd_en, wr_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [7:0]        wr_data;
    logic [1:0]        cfg_write_mode, cfg_func, cfg_read_map;
    logic [3:0]        cfg_set_reset, cfg_sr_en, cfg_map_mask;
    logic [7:0]        cfg_bit_mask;
    logic              rd_valid;
    logic [7:0]        rd_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] sh  [4][DEPTH];
    logic [7:0] lat [4];

    always #2.5 clk = ~clk;

    vga_planar_path #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .WIN_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cfg_write_mode(cfg_write_mode), .cfg_func(cfg_func),
        .cfg_read_map(cfg_read_map), .cfg_set_reset(cfg_set_reset),
        .cfg_sr_en(cfg_sr_en), .cfg_bit_mask(cfg_bit_mask),
        .cfg_map_mask(cfg_map_mask), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic inwin(input logic [19:0] a);
        return (a >= BASE) && (a < BASE + DEPTH);
    endfunction

    // expected byte for plane p, written per bit from the requirements
    function automatic logic [7:0] expect_byte(input int p, input logic [7:0] cpu,
                                               input logic [7:0] l);
        logic [7:0] r;
        logic s, f;
        if (cfg_write_mode == 2'd1 || cfg_write_mode == 2'd3) return l;
        for (int b = 0; b < 8; b++) begin
            if (cfg_write_mode == 2'd2) s = cpu[p];
            else if (cfg_sr_en[p])      s = cfg_set_reset[p];
            else                        s = cpu[b];
            case (cfg_func)
                2'd0: f = s;
                2'd1: f = s & l[b];
                2'd2: f = s | l[b];
                default: f = s ^ l[b];
            endcase
            r[b] = cfg_bit_mask[b] ? f : l[b];
        end
        return r;
    endfunction

    task automatic set_cfg(input logic [31:0] v);
        cfg_write_mode = v[31:30];
        cfg_func       = v[29:28];
        cfg_set_reset  = v[27:24];
        cfg_sr_en      = v[23:20];
        cfg_bit_mask   = v[19:12];
        cfg_map_mask   = v[11:8];
    endtask

    task automatic plain_cfg(input logic [3:0] map);
        set_cfg({4'h0, 4'h0, 4'h0, 8'hFF, map, 8'h00});
    endtask

    task automatic model_write(input logic [19:0] a, input logic [7:0] d);
        logic [7:0] o;
        if (inwin(a)) begin
            o = a[7:0] - BASE[7:0];
            for (int p = 0; p < 4; p++)
                if (cfg_map_mask[p]) sh[p][o] = expect_byte(p, d, lat[p]);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input logic [19:0] a, input logic [1:0] sel,
                            output logic v, output logic [7:0] d);
        logic [7:0] o;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a; cfg_read_map = sel;
        @(negedge clk);
        rd_en = 1'b0;
        cfg_read_map = sel + 2'd1;  // select must have been sampled already
        v = rd_valid; d = rd_data;
        if (inwin(a)) begin
            o = a[7:0] - BASE[7:0];
            for (int p = 0; p < 4; p++) lat[p] = sh[p][o];
        end
    endtask

    task automatic rd_check(input logic [19:0] a, input logic [1:0] sel, input string req);
        logic v;
        logic [7:0] d, e;
        e = sh[sel][a[7:0]];
        bus_read(a, sel, v, d);
        chk({req, " rd_valid"}, {7'd0, v}, 8'd1);
        chk(req, d, e);
    endtask

    task automatic load_latches(input logic [7:0] o, input int seed);
        logic v;
        logic [7:0] d;
        for (int p = 0; p < 4; p++) begin
            plain_cfg(4'(1 << p));
            bus_write(BASE + 20'(o), 8'(seed * 37 + p * 91 + 13));
        end
        bus_read(BASE + 20'(o), 2'd0, v, d);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic v;
        logic [7:0] d;
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        rd_addr = '0; wr_addr = '0; wr_data = '0; cfg_read_map = '0;
        plain_cfg(4'hF);
        for (int p = 0; p < 4; p++) lat[p] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 rd_valid in reset", {7'd0, rd_valid}, 8'd0);
        rst_n = 1'b1;

        // R1: latches start at zero, so a copy store writes zeros
        set_cfg(32'h400FFF00);
        bus_write(BASE + 20'd5, 8'hC3);
        for (int p = 0; p < 4; p++) sh[p][5] = 8'h00;
        for (int p = 0; p < 4; p++) rd_check(BASE + 20'd5, 2'(p), "R1 zero latch copy");

        // seed every offset with a known byte
        plain_cfg(4'hF);
        for (int o = 0; o < DEPTH; o++) bus_write(BASE + 20'(o), 8'(o ^ 8'h5A));

        // table of write configurations
        for (int i = 0; i < NVEC; i++) begin
            load_latches(8'h10, i);
            set_cfg(VEC[i]);
            bus_write(BASE + 20'(8'h20 + i), VEC[i][7:0]);
            for (int p = 0; p < 4; p++)
                rd_check(BASE + 20'(8'h20 + i), 2'(p), $sformatf("R5-R10 vector %0d", i));
        end

        // R3: read-plane select sampled at request
        rd_check(BASE + 20'h21, 2'd2, "R3 select sampled");

        // R2: read outside window, both sides
        load_latches(8'h11, 99);
        bus_read(BASE - 20'd1, 2'd0, v, d);
        chk("R2 rd below window", {7'd0, v}, 8'd0);
        bus_read(BASE + 20'(DEPTH), 2'd0, v, d);
        chk("R2 rd above window", {7'd0, v}, 8'd0);
        set_cfg(32'h400FFF00);
        bus_write(BASE + 20'h50, 8'h00);
        for (int p = 0; p < 4; p++) rd_check(BASE + 20'h50, 2'(p), "R2 R4 latches kept");

        // R2: write outside window must not alias onto offset 0 or the top
        plain_cfg(4'hF);
        bus_write(BASE + 20'(DEPTH), 8'hEE);
        bus_write(BASE - 20'd1, 8'hDD);
        for (int p = 0; p < 4; p++) rd_check(BASE, 2'(p), "R2 wr above window");
        rd_check(BASE + 20'(DEPTH - 1), 2'd1, "R2 wr below window");

        // R11: read and copy-write at the same offset in one cycle
        load_latches(8'h31, 7);
        set_cfg(32'h400FFF00);
        begin
            logic [7:0] old [4];
            logic [7:0] e;
            for (int p = 0; p < 4; p++) old[p] = sh[p][8'h30];
            e = old[3];
            @(negedge clk);
            rd_en = 1'b1; rd_addr = BASE + 20'h30; cfg_read_map = 2'd3;
            wr_en = 1'b1; wr_addr = BASE + 20'h30; wr_data = 8'h99;
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
            chk("R11 read sees old byte", rd_data, e);
            for (int p = 0; p < 4; p++) sh[p][8'h30] = lat[p];
            for (int p = 0; p < 4; p++) lat[p] = old[p];
        end
        for (int p = 0; p < 4; p++) rd_check(BASE + 20'h30, 2'(p), "R11 write used old latch");

        // random mix over a small region
        for (int k = 0; k < 120; k++) begin
            logic [31:0] r;
            logic [19:0] a;
            r = $urandom;
            a = BASE + 20'(8'h40 + r[2:0]);
            if (r[3]) begin
                set_cfg($urandom);
                bus_write(a, r[15:8]);
            end else begin
                rd_check(a, r[5:4], "R3 R4 random read");
            end
        end
        for (int o = 8'h40; o < 8'h48; o++)
            for (int p = 0; p < 4; p++) rd_check(BASE + 20'(o), 2'(p), "R10 final plane sweep");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule